// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is a bus master that turns one request from a core into one complete read or write machine cycle on a bus with 16 shared address/data lines and a 20-bit address. Every clock period is one bus state. A cycle always runs through an address state (T1), a command state (T2), a data state (T3), any number of wait states (Tw), and a closing state (T4). In the address state the low sixteen address bits go out on the shared lines and a one-cycle strobe lets external logic latch them. The same shared lines then carry write data, or they are released so that a memory or port can drive read data.

The four upper address lines carry address bits 19..16 in T1 and a status pattern after that. A bus-ready input is sampled at the end of T3 and at the end of each wait state, which lets a slow device stretch the cycle. The sequencer also drives a memory/port select, active-low read and write strobes, a transceiver direction bit, an active-low transceiver enable and an active-low high-byte enable. When the cycle ends, a one-cycle done pulse is raised and the captured read word is presented with it. A request is taken only while the sequencer is idle.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is held, and after it until a request is taken: addr_strobe=0, read_n=1, write_n=1, xcvr_en_n=1, byte_hi_n=1, bus_oe=0, mem_sel=0, dir_tx=0, upper_out=0, done=0, rdata=0, req_ready=1.
- R2: A request (req_valid=1) is taken only at a rising edge where req_ready=1. req_ready is 0 from T1 through T4. A req_valid raised during T2..T4 and dropped in T4 starts no cycle.
- R3: The cycle after the accepting edge is T1. In T1 addr_strobe=1 (and it is 0 in every other state), bus_oe=1, bus_out=req_addr[15:0], upper_out=req_addr[19:16]. byte_hi_n is the inverse of req_hbe from T1 through T4 and is 1 otherwise.
- R4: From T2 through T4, upper_out bit 3 is 0, bit 2 equals req_ie as it was at the accepting edge, and bits 1..0 are 0.
- R5: In a read cycle, read_n=0 in T2, T3 and every Tw, and read_n=1 in T1 and T4. bus_oe=0 from T2 through T4.
- R6: In a write cycle, write_n=0 in T2, T3 and every Tw, and write_n=1 in T1 and T4. From T2 through T4, bus_oe=1 and bus_out=req_wdata.
- R7: Each time bus_ready is 0 at the edge ending T3 or a Tw, one more Tw follows. The command strobe is therefore low for exactly 2+N cycles when N wait states are inserted. T4 follows the first edge where bus_ready=1.
- R8: On a read, rdata takes bus_in as sampled at the edge that ends the last T3/Tw. Later changes to bus_in do not alter it.
- R9: done is 1 for exactly the one cycle after T4 and 0 otherwise. req_ready is 1 in that cycle.
- R10: mem_sel equals req_mem and dir_tx equals req_write from T1 through T4, and both are 0 when idle.
- R11: xcvr_en_n=0 in T2, T3 and every Tw, and it is 1 in T1, T4 and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one bus state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_mem | input | 1 | 1 = memory space, 0 = port space |
| req_hbe | input | 1 | Enable the high byte lane |
| req_ie | input | 1 | Interrupt-enable flag shown in status |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-cycle end-of-cycle pulse |
| rdata | output | 16 | Captured read word |
| addr_strobe | output | 1 | Address latch pulse in T1 |
| mem_sel | output | 1 | Memory (1) or port (0) access |
| read_n | output | 1 | Active-low read strobe |
| write_n | output | 1 | Active-low write strobe |
| dir_tx | output | 1 | Transceiver direction, 1 = outward |
| xcvr_en_n | output | 1 | Active-low transceiver enable |
| byte_hi_n | output | 1 | Active-low high-byte enable |
| bus_out | output | 16 | Shared-line output value |
| bus_in | input | 16 | Shared-line input value |
| bus_oe | output | 1 | Shared-line output enable |
| upper_out | output | 4 | Upper address, then status |
| bus_ready | input | 1 | Device ready, sampled at end of T3/Tw |

## Verification
Every pin is registered from the state being entered, so each state's pin values are present throughout that state. T1 begins one cycle after the accepting edge, T4 begins one cycle after the first edge that sees ready high, and done and the captured word appear one cycle after T4. The bench drives inputs and samples outputs at falling clock edges. It walks through each cycle one state at a time, checks all pins against the values that state should have, counts the cycles in which a command strobe is low, and changes bus_in right after the capture edge to show that the captured word holds.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;
endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       ready,
  output bus_state_e cur,
  output bus_state_e nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_IDLE: if (start) nxt = ST_T1;
      ST_T1:   nxt = ST_T2;
      ST_T2:   nxt = ST_T3;
      ST_T3,
      ST_TW:   nxt = ready ? ST_T4 : ST_TW;
      ST_T4:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end

  // R7
  wait_insert_chk: assert property (@(posedge clk) disable iff (rst)
    ((cur == ST_T3 || cur == ST_TW) && !ready) |=> (cur == ST_TW));
  // R3
  t1_single_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_T1) |=> (cur == ST_T2));
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_state_e        cur,
  input  bus_state_e        nxt,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [DATA_W-1:0] q_wdata,
  input  logic              q_write,
  input  logic              q_mem,
  input  logic              q_hbe,
  input  logic              q_ie,
  input  logic [DATA_W-1:0] bus_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              addr_strobe,
  output logic              mem_sel,
  output logic              read_n,
  output logic              write_n,
  output logic              dir_tx,
  output logic              xcvr_en_n,
  output logic              byte_hi_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [ADDR_W-DATA_W-1:0] upper_out
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic in_cycle, cmd_ph, tail_ph;
  logic [HI_W-1:0] status_w;

  assign in_cycle = (nxt != ST_IDLE);
  assign cmd_ph   = (nxt == ST_T2) || (nxt == ST_T3) || (nxt == ST_TW);
  assign tail_ph  = cmd_ph || (nxt == ST_T4);

  // status pattern: top bit 0, next bit the interrupt flag, rest 0
  generate
    if (HI_W >= 2) begin : g_status
      always_comb begin
        status_w = '0;
        status_w[HI_W-2] = q_ie;
      end
    end else begin : g_status_narrow
      assign status_w = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_strobe <= 1'b0;
      mem_sel     <= 1'b0;
      read_n      <= 1'b1;
      write_n     <= 1'b1;
      dir_tx      <= 1'b0;
      xcvr_en_n   <= 1'b1;
      byte_hi_n   <= 1'b1;
      bus_out     <= '0;
      bus_oe      <= 1'b0;
      upper_out   <= '0;
      done        <= 1'b0;
      rdata       <= '0;
    end else begin
      addr_strobe <= (nxt == ST_T1);
      mem_sel     <= in_cycle && q_mem;
      dir_tx      <= in_cycle && q_write;
      byte_hi_n   <= !(in_cycle && q_hbe);
      read_n      <= !(cmd_ph && !q_write);
      write_n     <= !(cmd_ph && q_write);
      xcvr_en_n   <= !cmd_ph;
      bus_oe      <= (nxt == ST_T1) || (tail_ph && q_write);
      if (nxt == ST_T1)
        bus_out <= q_addr[DATA_W-1:0];
      else if (tail_ph && q_write)
        bus_out <= q_wdata;
      else
        bus_out <= '0;
      if (nxt == ST_T1)
        upper_out <= q_addr[ADDR_W-1:DATA_W];
      else if (tail_ph)
        upper_out <= status_w;
      else
        upper_out <= '0;
      if (nxt == ST_T4 && cur != ST_T4 && !q_write)
        rdata <= bus_in;
      done <= (cur == ST_T4);
    end
  end

  // R5
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(!read_n && !write_n));
  // R5
  read_released_chk: assert property (@(posedge clk) disable iff (rst)
    !read_n |-> !bus_oe);
  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |=> !addr_strobe);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  space_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cur != ST_IDLE && cur != ST_T4) |=> $stable(mem_sel));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic              req_hbe,
  input  logic              req_ie,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              addr_strobe,
  output logic              mem_sel,
  output logic              read_n,
  output logic              write_n,
  output logic              dir_tx,
  output logic              xcvr_en_n,
  output logic              byte_hi_n,
  output logic [DATA_W-1:0] bus_out,
  input  logic [DATA_W-1:0] bus_in,
  output logic              bus_oe,
  output logic [ADDR_W-DATA_W-1:0] upper_out,
  input  logic              bus_ready
);
  bus_state_e cur, nxt;
  logic start;

  logic [ADDR_W-1:0] addr_q, addr_e;
  logic [DATA_W-1:0] wdata_q, wdata_e;
  logic write_q, mem_q, hbe_q, ie_q;
  logic write_e, mem_e, hbe_e, ie_e;

  assign req_ready = (cur == ST_IDLE);
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      mem_q   <= 1'b0;
      hbe_q   <= 1'b0;
      ie_q    <= 1'b0;
    end else if (start) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      mem_q   <= req_mem;
      hbe_q   <= req_hbe;
      ie_q    <= req_ie;
    end
  end

  // at the accepting edge the pin registers see the incoming request
  assign addr_e  = start ? req_addr  : addr_q;
  assign wdata_e = start ? req_wdata : wdata_q;
  assign write_e = start ? req_write : write_q;
  assign mem_e   = start ? req_mem   : mem_q;
  assign hbe_e   = start ? req_hbe   : hbe_q;
  assign ie_e    = start ? req_ie    : ie_q;

  mbs_fsm i_fsm (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ready (bus_ready),
    .cur   (cur),
    .nxt   (nxt)
  );

  mbs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
    .clk         (clk),
    .rst         (rst),
    .cur         (cur),
    .nxt         (nxt),
    .q_addr      (addr_e),
    .q_wdata     (wdata_e),
    .q_write     (write_e),
    .q_mem       (mem_e),
    .q_hbe       (hbe_e),
    .q_ie        (ie_e),
    .bus_in      (bus_in),
    .done        (done),
    .rdata       (rdata),
    .addr_strobe (addr_strobe),
    .mem_sel     (mem_sel),
    .read_n      (read_n),
    .write_n     (write_n),
    .dir_tx      (dir_tx),
    .xcvr_en_n   (xcvr_en_n),
    .byte_hi_n   (byte_hi_n),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .upper_out   (upper_out)
  );

  // R2
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe || !read_n || !write_n) |-> !req_ready);
endmodule

// File: tb/test_mux_bus_seq.sv
`timescale 1ns/1ps
module test_mux_bus_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_hbe = 1'b0, req_ie = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] bus_in = '0;
  logic bus_ready = 1'b0;
  logic req_ready, done, addr_strobe, mem_sel, read_n, write_n, dir_tx, xcvr_en_n, byte_hi_n, bus_oe;
  logic [15:0] rdata, bus_out;
  logic [3:0] upper_out;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mem(req_mem), .req_hbe(req_hbe), .req_ie(req_ie), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
    .addr_strobe(addr_strobe), .mem_sel(mem_sel), .read_n(read_n), .write_n(write_n),
    .dir_tx(dir_tx), .xcvr_en_n(xcvr_en_n), .byte_hi_n(byte_hi_n), .bus_out(bus_out),
    .bus_in(bus_in), .bus_oe(bus_oe), .upper_out(upper_out), .bus_ready(bus_ready)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ph: 0 idle, 1 T1, 2 T2/T3/Tw, 3 T4
  task automatic expect_pins(int ph, bit wr, bit mem, bit hbe, bit ie,
                             logic [19:0] a, logic [15:0] wd);
    logic [15:0] e_out;
    logic [3:0]  e_up;
    e_out = (ph == 1) ? a[15:0] : ((wr && ph >= 2) ? wd : 16'h0);
    e_up  = (ph == 1) ? a[19:16] : ((ph >= 2) ? {1'b0, ie, 2'b00} : 4'h0);
    check("R3", "addr_strobe", addr_strobe, ph == 1);
    check("R3", "byte_hi_n", byte_hi_n, !(ph != 0 && hbe));
    check("R5", "read_n", read_n, !(ph == 2 && !wr));
    check("R6", "write_n", write_n, !(ph == 2 && wr));
    check("R11", "xcvr_en_n", xcvr_en_n, !(ph == 2));
    check("R5", "bus_oe", bus_oe, (ph == 1) || (wr && ph >= 2));
    if (bus_oe) check("R6", "bus_out", bus_out, e_out);
    check("R4", "upper_out", upper_out, e_up);
    check("R10", "mem_sel", mem_sel, ph != 0 && mem);
    check("R10", "dir_tx", dir_tx, ph != 0 && wr);
    check("R2", "req_ready", req_ready, ph == 0);
    check("R9", "done", done, 1'b0);
  endtask

  task automatic bus_op(bit wr, bit mem, bit hbe, bit ie, logic [19:0] a,
                        logic [15:0] wd, logic [15:0] rin, int nwait, bit intrude);
    int strobe_cycles = 0;
    logic [15:0] rd_prev;
    rd_prev = rdata;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mem = mem; req_hbe = hbe; req_ie = ie;
    req_addr = a; req_wdata = wd; bus_ready = 1'b0; bus_in = ~rin;
    @(negedge clk);                         // T1
    req_valid = 1'b0; req_ie = !ie;         // later flag change must not show (R4)
    expect_pins(1, wr, mem, hbe, ie, a, wd);
    @(negedge clk);                         // T2
    expect_pins(2, wr, mem, hbe, ie, a, wd);
    if (!read_n || !write_n) strobe_cycles++;
    if (intrude) begin                      // R2 request while busy
      req_valid = 1'b1; req_addr = ~a; req_write = !wr;
    end
    @(negedge clk);                         // T3
    expect_pins(2, wr, mem, hbe, ie, a, wd);
    if (!read_n || !write_n) strobe_cycles++;
    bus_ready = (nwait == 0); bus_in = rin;
    for (int w = 0; w < nwait; w++) begin
      @(negedge clk);                       // Tw (R7)
      expect_pins(2, wr, mem, hbe, ie, a, wd);
      if (!read_n || !write_n) strobe_cycles++;
      bus_ready = (w == nwait - 1);
    end
    @(negedge clk);                         // T4
    expect_pins(3, wr, mem, hbe, ie, a, wd);
    check("R7", "command strobe cycles", strobe_cycles, 2 + nwait);
    bus_in = ~rin; bus_ready = 1'b0; req_valid = 1'b0;
    @(negedge clk);                         // done cycle
    check("R9", "done pulse", done, 1'b1);
    check("R9", "req_ready at done", req_ready, 1'b1);
    check("R8", "rdata", rdata, wr ? rd_prev : rin);
    @(negedge clk);
    check("R9", "done cleared", done, 1'b0);
    check("R8", "rdata held", rdata, wr ? rd_prev : rin);
    check("R2", "no extra cycle", addr_strobe, 1'b0);
    @(negedge clk);
    check("R2", "still idle", req_ready, 1'b1);
    check("R2", "no extra strobe", addr_strobe, 1'b0);
  endtask

  task automatic reset_test();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "rdata", rdata, 16'h0);
    expect_pins(0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    expect_pins(0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0, 16'h0);
    check("R1", "rdata after reset", rdata, 16'h0);
  endtask

  task automatic read_mem_nowait();
    bus_op(1'b0, 1'b1, 1'b1, 1'b1, 20'hA5C3E, 16'h0, 16'h1234, 0, 1'b0);
  endtask
  task automatic read_port_waits();
    bus_op(1'b0, 1'b0, 1'b0, 1'b0, 20'h0FFE4, 16'h0, 16'hBEEF, 2, 1'b0);
  endtask
  task automatic write_mem_wait();
    bus_op(1'b1, 1'b1, 1'b1, 1'b0, 20'hF8000, 16'hC0DE, 16'h5555, 1, 1'b0);
  endtask
  task automatic write_port_nowait();
    bus_op(1'b1, 1'b0, 1'b0, 1'b1, 20'h3FFF1, 16'h00FF, 16'hAAAA, 0, 1'b0);
  endtask
  task automatic busy_request_ignored();
    bus_op(1'b0, 1'b1, 1'b0, 1'b1, 20'h12345, 16'h0, 16'h8001, 1, 1'b1);
  endtask
  task automatic long_read();
    bus_op(1'b0, 1'b1, 1'b1, 1'b1, 20'hFFFF0, 16'h0, 16'h7E81, 4, 1'b0);
  endtask

  initial begin
    reset_test();
    read_mem_nowait();
    read_port_waits();
    write_mem_wait();
    write_port_nowait();
    busy_request_ignored();
    long_read();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule